// File: doc/BRIEF.md
# Debounced Manual Reset Detector

This block watches a push-switch reset input that is driven high while the switch is pressed. It samples the input only on a slow oscillator tick, and it accepts a press only when the input is seen high on a set number of consecutive ticks. Shorter highs are treated as glitches and have no effect. Once a press is accepted, the block pulls its active-low reset output low. It also asks the interval counters to clear and forces the wake output low. The reset is held for as long as the switch stays pressed.

After release, the block waits through a debounce period and then a full reset pulse before it lets the reset go. A high sample during the debounce period restarts that period. If the press comes while the system is still in its startup phase (power-on or interval measurement), the block also raises a startup-abort request. That request is held until the switch is released, so startup restarts on release while the reset pulse continues. The raw input is synchronised with two flops before it is used.

Top module: `mrst_qualifier`

## Requirements
- R1: After rst_n is released, rst_out_n is 1 and clr_cnt, wake_force_low and startup_abort are all 0.
- R2: An input that is high on fewer than QUAL_TICKS consecutive ticks leaves rst_out_n at 1.
- R3: A press seen high on QUAL_TICKS consecutive ticks (default 2) drives rst_out_n low after the clock edge of the last of those ticks.
- R4: While rst_out_n is low, clr_cnt and wake_force_low are both 1. While it is high, both are 0.
- R5: rst_out_n stays low for as long as the synchronised input is high after a valid press.
- R6: rst_out_n returns to 1 on the (DB_TICKS + PULSE_TICKS)-th tick after the last tick that sampled the input high. This is 34 ticks with the defaults.
- R7: A high sample during the debounce period keeps reset low and restarts the debounce count. The R6 timing then runs from that sample.
- R8: A valid press while startup_phase is 1 raises startup_abort. startup_abort stays 1 while the input is held, even if startup_phase falls. It drops on the first tick that samples the input low, while rst_out_n is still low.
- R9: A valid press while startup_phase is 0 leaves startup_abort at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| osc_tick | input | 1 | One-clock enable per slow oscillator period |
| mr_raw | input | 1 | Raw manual-reset level from the switch, active high |
| startup_phase | input | 1 | High while power-on or interval measurement is running |
| clr_cnt | output | 1 | Request to clear the interval counters |
| startup_abort | output | 1 | Request to abort the startup phase and restart it on release |
| wake_force_low | output | 1 | Forces the wake output to its low default |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
A qualification counter stuck in the wrong state shows at once as a reset that appears on a single-tick glitch, or that does not appear after two high ticks. A wrong debounce or pulse count shows only at the end of the release sequence, as a release-to-deassert tick count that differs from 34. The bench counts this every tick. A startup-abort flag that is not sticky, or that is cleared at the wrong time, shows within one tick of startup_phase falling or of the switch being released.

// File: rtl/mrst_qualifier.sv
module mrst_qualifier #(
  parameter int QUAL_TICKS  = 2,
  parameter int DB_TICKS    = 2,
  parameter int PULSE_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic mr_raw,
  input  logic startup_phase,
  output logic clr_cnt,
  output logic startup_abort,
  output logic wake_force_low,
  output logic rst_out_n
);
  localparam int QW   = $clog2(QUAL_TICKS + 1);
  localparam int TMAX = (DB_TICKS > PULSE_TICKS) ? DB_TICKS : PULSE_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {IDLE, HELD, DBNC, PULSE} st_t;

  st_t st, st_nxt;
  logic s1, s2;
  logic [QW-1:0] hi_cnt, hi_nxt;
  logic [TW-1:0] t_cnt, t_nxt;
  logic abort_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= mr_raw;
      s2 <= s1;
    end

  always_comb begin
    st_nxt = st;
    hi_nxt = hi_cnt;
    t_nxt  = t_cnt;
    if (osc_tick) begin
      case (st)
        IDLE:
          if (!s2) hi_nxt = '0;
          else if (hi_cnt == QW'(QUAL_TICKS - 1)) begin
            st_nxt = HELD;
            hi_nxt = '0;
          end else hi_nxt = hi_cnt + 1'b1;
        HELD:
          if (!s2) begin
            if (DB_TICKS == 1) begin
              st_nxt = PULSE;
              t_nxt  = '0;
            end else begin
              st_nxt = DBNC;
              t_nxt  = TW'(1);
            end
          end
        DBNC:
          if (s2) t_nxt = '0;
          else if (t_cnt == TW'(DB_TICKS - 1)) begin
            st_nxt = PULSE;
            t_nxt  = '0;
          end else t_nxt = t_cnt + 1'b1;
        default:
          if (t_cnt == TW'(PULSE_TICKS - 1)) begin
            st_nxt = IDLE;
            t_nxt  = '0;
          end else t_nxt = t_cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= IDLE;
      hi_cnt  <= '0;
      t_cnt   <= '0;
      abort_q <= 1'b0;
    end else begin
      st      <= st_nxt;
      hi_cnt  <= hi_nxt;
      t_cnt   <= t_nxt;
      abort_q <= (st_nxt == HELD) && (abort_q || startup_phase);
    end

  assign rst_out_n      = (st == IDLE);
  assign clr_cnt        = (st != IDLE);
  assign wake_force_low = (st != IDLE);
  assign startup_abort  = abort_q;
endmodule

module mrst_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_tick,
  input logic startup_phase,
  input logic mr_s2,
  input logic in_pulse,
  input logic clr_cnt,
  input logic startup_abort,
  input logic wake_force_low,
  input logic rst_out_n
);
  AST_FALL_NEEDS_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(mr_s2 && osc_tick)); // R3
  AST_SIDE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (clr_cnt && wake_force_low)); // R4
  AST_RELEASE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(in_pulse && osc_tick)); // R6
  AST_ABORT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    startup_abort |-> !rst_out_n); // R8
  AST_ABORT_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup_abort) |-> $past(startup_phase)); // R8
  AST_ABORT_DROP_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(startup_abort) |-> $past(!mr_s2 && osc_tick)); // R8
endmodule

bind mrst_qualifier mrst_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .startup_phase(startup_phase),
  .mr_s2(s2), .in_pulse(st == PULSE), .clr_cnt(clr_cnt),
  .startup_abort(startup_abort), .wake_force_low(wake_force_low),
  .rst_out_n(rst_out_n)
);

// File: tb/sim_mrst_qualifier.sv
module sim_mrst_qualifier;
  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, mr_raw = 1'b0, startup_phase = 1'b0;
  logic clr_cnt, startup_abort, wake_force_low, rst_out_n;
  int checks = 0, failures = 0, div = 0, cyc = 0;

  localparam int REL_TICKS = 34;

  mrst_qualifier u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .mr_raw(mr_raw),
    .startup_phase(startup_phase), .clr_cnt(clr_cnt), .startup_abort(startup_abort),
    .wake_force_low(wake_force_low), .rst_out_n(rst_out_n)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    div <= (div == 7) ? 0 : div + 1;
    osc_tick <= (div == 6);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk iff osc_tick);
    @(negedge clk);
  endtask

  task automatic press_valid();
    mr_raw = 1'b1;
    tick();
    check("R3 not yet after one tick", rst_out_n, 1);
    tick();
    check("R3 reset after two ticks", rst_out_n, 0);
  endtask

  task automatic measure_release(input string tag);
    int n = 0;
    while (rst_out_n == 1'b0 && n < 100) begin
      tick();
      n++;
      if (rst_out_n == 1'b0) check("R4 clr and wake during reset", clr_cnt & wake_force_low, 1);
    end
    check(tag, n, REL_TICKS);
    check("R4 clr and wake after release", clr_cnt | wake_force_low, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R1 rst_out_n", rst_out_n, 1);
    check("R1 clr_cnt", clr_cnt, 0);
    check("R1 wake_force_low", wake_force_low, 0);
    check("R1 startup_abort", startup_abort, 0);
  endtask

  task automatic t_glitch();
    mr_raw = 1'b1;
    tick();
    mr_raw = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R2 glitch ignored", rst_out_n, 1);
    end
  endtask

  task automatic t_press_hold_release();
    press_valid();
    check("R4 clr_cnt on press", clr_cnt, 1);
    check("R4 wake_force_low on press", wake_force_low, 1);
    check("R9 no abort outside startup", startup_abort, 0);
    for (int i = 0; i < 10; i++) begin
      tick();
      check("R5 held while pressed", rst_out_n, 0);
    end
    mr_raw = 1'b0;
    measure_release("R6 release to deassert ticks");
  endtask

  task automatic t_bounce();
    press_valid();
    tick();
    mr_raw = 1'b0;
    tick();
    mr_raw = 1'b1;
    tick();
    check("R7 still low on bounce", rst_out_n, 0);
    mr_raw = 1'b0;
    measure_release("R7 debounce restarted");
  endtask

  task automatic t_abort();
    startup_phase = 1'b1;
    press_valid();
    check("R8 abort raised", startup_abort, 1);
    startup_phase = 1'b0;
    tick();
    tick();
    check("R8 abort held after phase drops", startup_abort, 1);
    mr_raw = 1'b0;
    tick();
    check("R8 abort dropped on release", startup_abort, 0);
    check("R8 reset still low at abort drop", rst_out_n, 0);
    for (int i = 0; i < 40 && rst_out_n == 1'b0; i++) tick();
    check("R8 reset released later", rst_out_n, 1);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_press_hold_release();
    tick();
    t_bounce();
    tick();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule